// File: doc/BRIEF.md
# Radio transceiver state controller

This block sequences the operating modes of a low-power packet radio. It keeps the current mode (power-on, off, sleep, receive listening, receive with clock output stopped, synthesizer locked, receiving a frame, sending a frame) and publishes a status code that software reads back after each request. Mode changes come from four sources: state-change commands written by software, edges on a level control pin for sleep and transmit, an active-low reset pin, and frame start/end strobes from the modem.

Commands arrive on a valid/ready channel. `cmd_ready` is low while a timed mode change is in progress and while the reset pin is asserted. A command offered during that time is not lost: the source holds `cmd_valid` and `cmd_code` steady until it sees `cmd_ready` high at a clock edge. Every mode change caused by a command or by the control pin runs a delay window. During the window the status reads the transitional code, and the enables already follow the destination mode. Frame strobes and the transmit start switch modes at once, with no window. Commands that are not legal in the current mode are dropped and raise a single-cycle error flag.

The control pin passes through a synchronizer of `SYNC_STAGES` flops. The clock-output rate setting is written through `cfg_wr`. The power-on reset `rst_n` clears it, and the reset pin leaves it unchanged.

Top module: `radio_state_ctrl`

## Requirements
- R1: An accepted command that changes mode makes `status` read 0x1F for exactly TRANS_DLY cycles, or WAKE_DLY cycles when leaving sleep, and then read the destination code. `cmd_ready` is low during that window and while `rst_pin_n` is low. Pin edges and frame strobes that arrive during a window are dropped.
- R2: Commands are encoded in `cmd_code` as 0 none, 1 off, 2 forced off, 3 receive, 4 PLL on, 5 fast PLL on. Codes 6 and 7 are illegal. Off (1) and forced off (2) lead to TRX_OFF from every mode except sleep, where both are rejected. Leaving P_ON with off or forced off also requires that the oscillator-stable indication has been seen.
- R3: In BUSY_RX or BUSY_TX, forced off starts the window to TRX_OFF at once, and `pll_en` drops in the same cycle. Plain off is stored and applied when the done strobe arrives, including when the command and the strobe come in the same cycle.
- R4: Fast PLL on (5) moves RX_ON, BUSY_RX or BUSY_TX to PLL_ON, and keeps `pll_en` and `reg_en` high through the whole window.
- R5: Fast PLL on is rejected in P_ON, TRX_OFF, SLEEP and RX_ON_NOCLK, and the mode is left unchanged.
- R6: A rising pin edge moves TRX_OFF to SLEEP and RX_ON to RX_ON_NOCLK, each through a window, and moves PLL_ON to BUSY_TX at once. A rising edge has no effect in any other mode.
- R7: A falling pin edge moves SLEEP to TRX_OFF and RX_ON_NOCLK to RX_ON. A falling edge has no effect in any other mode.
- R8: While `rst_pin_n` is low, the mode is forced to TRX_OFF, any window is aborted and any stored off is cleared. The one exception is P_ON, which stays P_ON. `clk_rate` keeps its value through this reset.
- R9: After `rst_n`, the mode is P_ON, `clk_rate` is 1, and `clk_out_en` stays low until `osc_stable` has been seen at a clock edge.
- R10: `frm_start` in RX_ON moves to BUSY_RX at once. `frm_done` returns BUSY_RX to RX_ON and BUSY_TX to PLL_ON at once, or starts a window to TRX_OFF if an off is stored. Strobes have no effect in other modes.
- R11: Receive (3) is legal from TRX_OFF and PLL_ON, and PLL on (4) is legal from TRX_OFF and RX_ON. A command naming the current mode does nothing. Every other rejected command, and every illegal code, raises `err_pulse` for one cycle, starting in the cycle after the command is accepted.
- R12: `pll_en` is high in RX_ON, RX_ON_NOCLK, PLL_ON and both busy modes. `reg_en` is high in those modes and in TRX_OFF. `clk_out_en` is high, once the oscillator is stable, in every mode except SLEEP and RX_ON_NOCLK. During a window all three follow the destination mode.
- R13: Status codes are P_ON 0x00, TRX_OFF 0x01, SLEEP 0x02, RX_ON 0x03, RX_ON_NOCLK 0x04, PLL_ON 0x05, BUSY_RX 0x06, BUSY_TX 0x07, and 0x1F during a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| osc_stable | input | 1 | Oscillator-stable indication |
| rst_pin_n | input | 1 | Reset pin, active low |
| slp_pin | input | 1 | Sleep/transmit control pin (asynchronous) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_code | input | 3 | Command code |
| frm_start | input | 1 | Modem strobe: frame reception begins |
| frm_done | input | 1 | Modem strobe: frame activity ends |
| cfg_wr | input | 1 | Write clock-output rate |
| cfg_rate | input | CLK_W | New clock-output rate |
| status | output | 5 | Status code |
| pll_en | output | 1 | Synthesizer enable |
| reg_en | output | 1 | Analog regulator enable |
| clk_out_en | output | 1 | Clock output enable |
| clk_rate | output | CLK_W | Clock-output rate setting |
| err_pulse | output | 1 | Rejected command flag, one cycle |

## Verification
Two pairs of functions can fall in the same cycle. First, a plain off command can be accepted in BUSY_TX in the same cycle as the done strobe. The bench raises `cmd_valid` with code 1 and `frm_done` together on one edge. It expects the transitional code and then TRX_OFF, not PLL_ON, and the scoreboard judges the result from the order of status codes. Second, a forced off can be accepted in BUSY_RX. Here the bench checks that `pll_en` falls in the first window cycle, whereas a fast PLL on from the same mode keeps it high.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [2:0] {
    ST_PON   = 3'd0,
    ST_OFF   = 3'd1,
    ST_SLEEP = 3'd2,
    ST_RX    = 3'd3,
    ST_RXNC  = 3'd4,
    ST_PLL   = 3'd5,
    ST_BRX   = 3'd6,
    ST_BTX   = 3'd7
  } rsc_state_e;

  localparam logic [4:0] STAT_TRANS = 5'h1F;

  localparam logic [2:0] C_NOP  = 3'd0;
  localparam logic [2:0] C_OFF  = 3'd1;
  localparam logic [2:0] C_FOFF = 3'd2;
  localparam logic [2:0] C_RX   = 3'd3;
  localparam logic [2:0] C_PLL  = 3'd4;
  localparam logic [2:0] C_FPLL = 3'd5;

  function automatic logic is_busy(input rsc_state_e s);
    return (s == ST_BRX) || (s == ST_BTX);
  endfunction

  function automatic logic need_pll(input rsc_state_e s);
    return (s == ST_RX) || (s == ST_RXNC) || (s == ST_PLL) || is_busy(s);
  endfunction

  function automatic logic need_reg(input rsc_state_e s);
    return need_pll(s) || (s == ST_OFF);
  endfunction

  function automatic logic has_clk(input rsc_state_e s);
    return (s != ST_SLEEP) && (s != ST_RXNC);
  endfunction

endpackage

// File: rtl/rsc_pin_edge.sv
module rsc_pin_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [SYNC:0] chain;
  logic          prev;

  assign chain[0] = pin;

  for (genvar g = 0; g < SYNC; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= 1'b0;
      else        chain[g+1] <= chain[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[SYNC];
  end

  assign rise = chain[SYNC] & ~prev;
  assign fall = ~chain[SYNC] & prev;
endmodule

// File: rtl/rsc_timer.sv
module rsc_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  input  logic          abort,
  output logic          busy,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= load - CW'(1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  assign expire = busy && (cnt == '0);
endmodule

// File: rtl/rsc_cmd_decode.sv
module rsc_cmd_decode
  import rsc_pkg::*;
(
  input  rsc_state_e state,
  input  logic       osc_ok,
  input  logic [2:0] code,
  output logic       go,
  output rsc_state_e tgt,
  output logic       pend,
  output logic       err
);
  always_comb begin
    go   = 1'b0;
    pend = 1'b0;
    err  = 1'b0;
    tgt  = state;
    case (code)
      C_NOP: ;
      C_OFF, C_FOFF: begin
        if (state == ST_SLEEP) begin
          err = 1'b1;
        end else if (state == ST_PON) begin
          if (osc_ok) begin go = 1'b1; tgt = ST_OFF; end
          else err = 1'b1;
        end else if (is_busy(state)) begin
          if (code == C_FOFF) begin go = 1'b1; tgt = ST_OFF; end
          else pend = 1'b1;
        end else if (state != ST_OFF) begin
          go = 1'b1; tgt = ST_OFF;
        end
      end
      C_RX: begin
        if (state == ST_OFF || state == ST_PLL) begin go = 1'b1; tgt = ST_RX; end
        else if (state != ST_RX) err = 1'b1;
      end
      C_PLL: begin
        if (state == ST_OFF || state == ST_RX) begin go = 1'b1; tgt = ST_PLL; end
        else if (state != ST_PLL) err = 1'b1;
      end
      C_FPLL: begin
        if (state == ST_RX || is_busy(state)) begin go = 1'b1; tgt = ST_PLL; end
        else if (state != ST_PLL) err = 1'b1;
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/rsc_outputs.sv
module rsc_outputs
  import rsc_pkg::*;
(
  input  rsc_state_e state,
  input  rsc_state_e tgt,
  input  logic       busy,
  input  logic       osc_ok,
  output logic [4:0] status,
  output logic       pll_en,
  output logic       reg_en,
  output logic       clk_out_en
);
  rsc_state_e eff;

  always_comb begin
    eff        = busy ? tgt : state;
    status     = busy ? STAT_TRANS : {2'b00, state};
    pll_en     = need_pll(eff);
    reg_en     = need_reg(eff);
    clk_out_en = osc_ok && has_clk(eff);
  end
endmodule

// File: rtl/radio_state_ctrl.sv
module radio_state_ctrl
  import rsc_pkg::*;
#(
  parameter int          TRANS_DLY   = 4,
  parameter int          WAKE_DLY    = 6,
  parameter int          SYNC_STAGES = 2,
  parameter int          CLK_W       = 3,
  parameter logic [CLK_W-1:0] CLK_DEF = CLK_W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_stable,
  input  logic             rst_pin_n,
  input  logic             slp_pin,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_code,
  input  logic             frm_start,
  input  logic             frm_done,
  input  logic             cfg_wr,
  input  logic [CLK_W-1:0] cfg_rate,
  output logic [4:0]       status,
  output logic             pll_en,
  output logic             reg_en,
  output logic             clk_out_en,
  output logic [CLK_W-1:0] clk_rate,
  output logic             err_pulse
);
  localparam int DMAX = (TRANS_DLY > WAKE_DLY) ? TRANS_DLY : WAKE_DLY;
  localparam int CW   = $clog2(DMAX + 1);
  localparam logic [CW-1:0] L_TRANS = CW'(TRANS_DLY);
  localparam logic [CW-1:0] L_WAKE  = CW'(WAKE_DLY);

  rsc_state_e    state, tgt;
  logic          pend, osc_ok, err_q;
  logic          busy, expire;
  logic          rise, fall;
  logic          fire;
  logic          dec_go, dec_pend, dec_err;
  rsc_state_e    dec_tgt;
  logic          start, imm;
  rsc_state_e    start_tgt, imm_st;
  logic [CW-1:0] dly;
  logic          pend_eff;

  rsc_pin_edge #(.SYNC(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(slp_pin), .rise(rise), .fall(fall)
  );

  rsc_cmd_decode u_dec (
    .state(state), .osc_ok(osc_ok), .code(cmd_code),
    .go(dec_go), .tgt(dec_tgt), .pend(dec_pend), .err(dec_err)
  );

  rsc_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .load(dly),
    .abort(!rst_pin_n), .busy(busy), .expire(expire)
  );

  rsc_outputs u_out (
    .state(state), .tgt(tgt), .busy(busy), .osc_ok(osc_ok),
    .status(status), .pll_en(pll_en), .reg_en(reg_en), .clk_out_en(clk_out_en)
  );

  assign cmd_ready = rst_pin_n && !busy;
  assign fire      = cmd_valid && cmd_ready;
  assign pend_eff  = pend || (fire && dec_pend);

  // One event per cycle; an accepted mode-changing command outranks strobes and pin edges.
  always_comb begin
    start     = 1'b0;
    imm       = 1'b0;
    start_tgt = state;
    imm_st    = state;
    dly       = L_TRANS;
    if (rst_pin_n && !busy) begin
      if (fire && dec_go) begin
        start     = 1'b1;
        start_tgt = dec_tgt;
      end else if (frm_done && is_busy(state)) begin
        if (pend_eff) begin
          start     = 1'b1;
          start_tgt = ST_OFF;
        end else begin
          imm    = 1'b1;
          imm_st = (state == ST_BRX) ? ST_RX : ST_PLL;
        end
      end else if (frm_start && state == ST_RX) begin
        imm    = 1'b1;
        imm_st = ST_BRX;
      end else if (rise) begin
        case (state)
          ST_OFF: begin start = 1'b1; start_tgt = ST_SLEEP; end
          ST_RX:  begin start = 1'b1; start_tgt = ST_RXNC;  end
          ST_PLL: begin imm   = 1'b1; imm_st    = ST_BTX;   end
          default: ;
        endcase
      end else if (fall) begin
        case (state)
          ST_SLEEP: begin start = 1'b1; start_tgt = ST_OFF; dly = L_WAKE; end
          ST_RXNC:  begin start = 1'b1; start_tgt = ST_RX;  end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_PON;
      tgt      <= ST_PON;
      pend     <= 1'b0;
      osc_ok   <= 1'b0;
      err_q    <= 1'b0;
      clk_rate <= CLK_DEF;
    end else begin
      osc_ok <= osc_ok || osc_stable;
      err_q  <= fire && dec_err;
      if (cfg_wr) clk_rate <= cfg_rate;
      if (!rst_pin_n) begin
        if (state != ST_PON) state <= ST_OFF;
        pend <= 1'b0;
      end else if (expire) begin
        state <= tgt;
      end else begin
        if (start) tgt <= start_tgt;
        if (imm)   state <= imm_st;
        if (start || imm)         pend <= 1'b0;
        else if (fire && dec_pend) pend <= 1'b1;
      end
    end
  end

  assign err_pulse = err_q;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int CLK_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_pin_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cfg_wr,
  input logic [4:0]       status,
  input logic             pll_en,
  input logic             reg_en,
  input logic             clk_out_en,
  input logic [CLK_W-1:0] clk_rate,
  input logic             err_pulse
);
  localparam logic [4:0] K_PON = 5'h00, K_OFF = 5'h01, K_SLEEP = 5'h02;
  localparam logic [4:0] K_BRX = 5'h06, K_BTX = 5'h07, K_TR = 5'h1F;

  p_no_cmd_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status == K_TR) |-> !cmd_ready);

  p_ready_low_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin_n |-> !cmd_ready);

  p_err_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(cmd_valid && cmd_ready));

  p_pin_reset_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pin_n && status != K_PON && status != K_TR) |=> (status == K_OFF));

  p_pin_reset_pon_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pin_n && status == K_PON) |=> (status == K_PON));

  p_rate_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pin_n && !cfg_wr) |=> $stable(clk_rate));

  p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status == K_SLEEP) |-> (!clk_out_en && !pll_en && !reg_en));

  p_busy_pll_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status == K_BRX || status == K_BTX) |-> (pll_en && reg_en));
endmodule

bind radio_state_ctrl rsc_checker #(.CLK_W(CLK_W)) u_rsc_chk (
  .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cfg_wr(cfg_wr), .status(status), .pll_en(pll_en),
  .reg_en(reg_en), .clk_out_en(clk_out_en), .clk_rate(clk_rate),
  .err_pulse(err_pulse)
);

// File: tb/radio_state_ctrl_tb_top.sv
module radio_state_ctrl_tb_top;
  localparam int T_TR = 4;
  localparam int T_WK = 6;
  localparam logic [4:0] S_PON = 5'h00, S_OFF = 5'h01, S_SLEEP = 5'h02, S_RX = 5'h03;
  localparam logic [4:0] S_RXNC = 5'h04, S_PLL = 5'h05, S_BRX = 5'h06, S_BTX = 5'h07;
  localparam logic [4:0] S_TR = 5'h1F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_stable = 1'b0, rst_pin_n = 1'b1, slp_pin = 1'b0;
  logic cmd_valid = 1'b0, frm_start = 1'b0, frm_done = 1'b0, cfg_wr = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [2:0] cfg_rate = 3'd0;
  logic cmd_ready, pll_en, reg_en, clk_out_en, err_pulse;
  logic [4:0] status;
  logic [2:0] clk_rate;

  int checks = 0, fails = 0;
  logic [4:0] exp_q[$];
  logic [4:0] last_st = 5'h00;
  bit mon_on = 1'b0;

  always #5 clk = ~clk;

  radio_state_ctrl #(.TRANS_DLY(T_TR), .WAKE_DLY(T_WK)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_stable(osc_stable), .rst_pin_n(rst_pin_n),
    .slp_pin(slp_pin), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .frm_start(frm_start), .frm_done(frm_done),
    .cfg_wr(cfg_wr), .cfg_rate(cfg_rate), .status(status), .pll_en(pll_en),
    .reg_en(reg_en), .clk_out_en(clk_out_en), .clk_rate(clk_rate),
    .err_pulse(err_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every status change must match the next expected code.
  always @(negedge clk) begin
    if (mon_on && status !== last_st) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R13 unexpected status change", int'(status), int'(last_st));
      end else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        chk(status === e, "R13 status sequence", int'(status), int'(e));
      end
      last_st = status;
    end
  end

  task automatic expect_win(input logic [4:0] dst);
    exp_q.push_back(S_TR);
    exp_q.push_back(dst);
  endtask

  task automatic send_cmd(input logic [2:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = c;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  task automatic bad_cmd(input logic [2:0] c, input string req, input logic [4:0] st);
    send_cmd(c);
    @(negedge clk);
    chk(err_pulse === 1'b1, req, int'(err_pulse), 1);
    @(negedge clk);
    chk(err_pulse === 1'b0, "R11 error lasts one cycle", int'(err_pulse), 0);
    chk(status === st, req, int'(status), int'(st));
  endtask

  task automatic strobe(input bit is_done);
    @(negedge clk);
    if (is_done) frm_done = 1'b1; else frm_start = 1'b1;
    @(negedge clk);
    frm_done = 1'b0;
    frm_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    chk(status === S_PON, "R9 reset status", int'(status), int'(S_PON));
    chk(clk_out_en === 1'b0, "R9 clock off before oscillator", int'(clk_out_en), 0);
    chk(clk_rate === 3'd1, "R9 default rate", int'(clk_rate), 1);
    chk(pll_en === 1'b0 && reg_en === 1'b0, "R12 P_ON enables", int'({pll_en, reg_en}), 0);

    bad_cmd(3'd1, "R2 off before oscillator stable", S_PON);
    osc_stable = 1'b1;
    repeat (2) @(negedge clk);
    chk(clk_out_en === 1'b1, "R9 clock on after oscillator", int'(clk_out_en), 1);

    // Reset pin in P_ON keeps P_ON
    @(negedge clk) rst_pin_n = 1'b0;
    @(negedge clk);
    chk(cmd_ready === 1'b0, "R1 ready low in pin reset", int'(cmd_ready), 0);
    @(negedge clk) rst_pin_n = 1'b1;
    @(negedge clk);
    chk(status === S_PON, "R8 P_ON survives reset pin", int'(status), int'(S_PON));

    bad_cmd(3'd5, "R5 fast PLL rejected in P_ON", S_PON);

    // P_ON -> TRX_OFF, measure the window
    expect_win(S_OFF);
    send_cmd(3'd1);
    begin
      int n = 0;
      @(negedge clk);
      chk(cmd_ready === 1'b0, "R1 ready low in window", int'(cmd_ready), 0);
      while (status === S_TR && n < 50) begin n++; @(negedge clk); end
      chk(n == T_TR, "R1 window length", n, T_TR);
    end
    chk(status === S_OFF && reg_en && !pll_en, "R12 TRX_OFF enables", int'(status), int'(S_OFF));

    bad_cmd(3'd5, "R5 fast PLL rejected in TRX_OFF", S_OFF);
    bad_cmd(3'd7, "R11 illegal code", S_OFF);
    strobe(1'b0);
    chk(status === S_OFF, "R10 start ignored in TRX_OFF", int'(status), int'(S_OFF));

    // Receive, frame, fast PLL on
    expect_win(S_RX);
    send_cmd(3'd3); settle();
    chk(pll_en === 1'b1, "R12 RX_ON PLL on", int'(pll_en), 1);
    exp_q.push_back(S_BRX);
    strobe(1'b0); settle();
    expect_win(S_PLL);
    send_cmd(3'd5);
    @(negedge clk);
    chk(status === S_TR && pll_en && reg_en, "R4 fast PLL keeps enables", int'({status, pll_en, reg_en}), 'h7F);
    settle();

    // Transmit via pin, plain off held until done
    exp_q.push_back(S_BTX);
    @(negedge clk) slp_pin = 1'b1;
    settle();
    @(negedge clk) slp_pin = 1'b0;
    settle();
    chk(status === S_BTX, "R7 fall ignored in BUSY_TX", int'(status), int'(S_BTX));
    send_cmd(3'd1);
    @(negedge clk);
    chk(err_pulse === 1'b0, "R3 plain off stored without error", int'(err_pulse), 0);
    settle();
    chk(status === S_BTX, "R3 plain off waits", int'(status), int'(S_BTX));
    expect_win(S_OFF);
    strobe(1'b1); settle();

    // Same-cycle plain off and done
    expect_win(S_PLL);
    send_cmd(3'd4); settle();
    exp_q.push_back(S_BTX);
    @(negedge clk) slp_pin = 1'b1;
    settle();
    expect_win(S_OFF);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 3'd1; frm_done = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0; frm_done = 1'b0;
    settle();
    chk(status === S_OFF, "R3 off and done in same cycle", int'(status), int'(S_OFF));
    @(negedge clk) slp_pin = 1'b0;
    settle();
    chk(status === S_OFF, "R7 fall ignored in TRX_OFF", int'(status), int'(S_OFF));

    // Forced off aborts reception
    expect_win(S_RX);
    send_cmd(3'd3); settle();
    exp_q.push_back(S_BRX);
    strobe(1'b0); settle();
    expect_win(S_OFF);
    send_cmd(3'd2);
    @(negedge clk);
    chk(status === S_TR && pll_en === 1'b0, "R3 forced off drops PLL", int'({status, pll_en}), 'h3E);
    settle();

    // Sleep
    expect_win(S_SLEEP);
    @(negedge clk) slp_pin = 1'b1;
    settle();
    chk(clk_out_en === 1'b0 && reg_en === 1'b0, "R6 sleep stops clock", int'({clk_out_en, reg_en}), 0);
    bad_cmd(3'd1, "R2 off rejected in SLEEP", S_SLEEP);
    bad_cmd(3'd5, "R5 fast PLL rejected in SLEEP", S_SLEEP);
    expect_win(S_OFF);
    @(negedge clk) slp_pin = 1'b0;
    begin
      int n = 0;
      while (status !== S_TR && n < 20) begin n++; @(negedge clk); end
      n = 0;
      while (status === S_TR && n < 50) begin n++; @(negedge clk); end
      chk(n == T_WK, "R1 wake window length", n, T_WK);
    end
    settle();

    // RX_ON_NOCLK round trip
    expect_win(S_RX);
    send_cmd(3'd3); settle();
    expect_win(S_RXNC);
    @(negedge clk) slp_pin = 1'b1;
    settle();
    chk(clk_out_en === 1'b0 && pll_en === 1'b1, "R6 RX_ON_NOCLK enables", int'({clk_out_en, pll_en}), 1);
    bad_cmd(3'd5, "R5 fast PLL rejected in RX_ON_NOCLK", S_RXNC);
    expect_win(S_RX);
    @(negedge clk) slp_pin = 1'b0;
    settle();

    // Frame without pending off
    exp_q.push_back(S_BRX);
    strobe(1'b0); settle();
    exp_q.push_back(S_RX);
    strobe(1'b1); settle();
    chk(status === S_RX, "R10 done returns to RX_ON", int'(status), int'(S_RX));
    bad_cmd(3'd4 + 3'd2, "R11 code 6 rejected", S_RX);

    // Rate setting kept across reset pin
    @(negedge clk) begin cfg_wr = 1'b1; cfg_rate = 3'd5; end
    @(negedge clk) cfg_wr = 1'b0;
    exp_q.push_back(S_OFF);
    @(negedge clk) rst_pin_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_pin_n = 1'b1;
    settle();
    chk(status === S_OFF, "R8 reset pin forces TRX_OFF", int'(status), int'(S_OFF));
    chk(clk_rate === 3'd5, "R8 rate kept", int'(clk_rate), 5);

    chk(exp_q.size() == 0, "R13 all expected codes seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule